// File: doc/BRIEF.md
# Open-Drain Two-Wire Bit Engine

This block runs the bit-level and byte-level signalling on a two-wire serial bus whose clock and data lines are both open drain. A controller above it gives one command at a time: create a start condition, create a stop condition, send a byte and collect the acknowledge, or receive a byte and then either acknowledge it or end the transfer with a not-acknowledge and a stop. The engine reports completion with a single-cycle `done` pulse and provides the received byte, the acknowledge result and a clock-stretch error flag.

Neither line is ever driven high. Each pad has only a pull-low enable, and a logic one is sent by releasing the line. Both line inputs pass through two-flop synchronizers. Each time the engine releases the clock, it waits until the line actually reads high, so a target device may stretch the clock. This wait is limited by a timeout. All hold times are given in microseconds and converted to clock ticks from a clock-frequency parameter.

Command codes on `cmd_op`: 2'b00 start, 2'b01 stop, 2'b10 write byte, 2'b11 read byte.

Top module: `twowire_bit_engine`

## Requirements
- R1: After reset, both pull-low enables are off and `busy`, `done`, `ack`, `err` are 0.
- R2: Each time the engine pulls the clock low, the clock stays low for at least the low-hold time (`LOW_US` converted to ticks) before the engine releases it.
- R3: After releasing the clock, the engine does not continue until the synchronized clock input reads high. A stretch that ends within `STRETCH_US` of the release is accepted with `err` = 0.
- R4: Start (code 00) releases data, then releases the clock, then pulls data low while the clock is high, and then pulls the clock low. On completion, both lines are held low.
- R5: Write (code 10) sends `cmd_wdata` most significant bit first. Each bit is placed on data while the clock is low and is held while the clock is high.
- R6: On the ninth clock of a write, the engine releases data. `ack` then becomes 1 if data reads low while the clock is high, and 0 otherwise.
- R7: After a write completes, the clock stays pulled low and data is released.
- R8: Read (code 11) builds `rdata` from the first eight clock-high samples, most significant bit first. With `cmd_last` = 0, it pulls data low during the ninth clock and then releases data.
- R9: A read with `cmd_last` = 1 leaves data released during the ninth clock and then makes a stop condition. Both lines are released on completion.
- R10: Stop (code 01) raises data while the clock is high. `done` does not appear until at least the bus-free time (`BUF_US` converted to ticks) has passed since data was released.
- R11: Each accepted command produces exactly one single-cycle `done` pulse. `cmd_valid` is ignored while `busy` is 1.
- R12: If the clock does not read high within the stretch limit, the engine abandons the command, releases both lines, and raises `err` together with `done`. `err` clears when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, accepted when not busy |
| cmd_op | input | 2 | Command code: 00 start, 01 stop, 10 write, 11 read |
| cmd_last | input | 1 | Read only: 1 sends not-acknowledge and stop |
| cmd_wdata | input | 8 | Byte to send on a write |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Single-cycle completion pulse |
| rdata | output | 8 | Byte from the latest read |
| ack | output | 1 | Acknowledge seen on the latest write |
| err | output | 1 | Clock-stretch timeout on the latest command |
| scl_in | input | 1 | Clock line level from the pad |
| sda_in | input | 1 | Data line level from the pad |
| scl_oe | output | 1 | Pull clock line low when 1 |
| sda_oe | output | 1 | Pull data line low when 1 |

## Verification
The stretch timer running out and the clock line rising can occur in the same tick. When that happens, the rise takes priority and the command continues. The bench tests this by holding the clock low with a model device for a period that ends a few tens of ticks before the limit; the command must then finish with `err` = 0. A hold that never ends must produce `err` = 1, with both lines released and `done` pulsed. The second function that can overlap a running command is a new `cmd_valid`. The bench pulses it in the middle of a write and checks that only one `done` appears and that the byte on the bus is unchanged.

// File: rtl/twowire_bit_engine.sv
module twowire_bit_engine #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int LOW_US     = 2,
  parameter int SETUP_US   = 1,
  parameter int BUF_US     = 60,
  parameter int STRETCH_US = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_last,
  input  logic [7:0] cmd_wdata,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdata,
  output logic       ack,
  output logic       err,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int TPU       = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int T_LOW     = (LOW_US * TPU < 1) ? 1 : LOW_US * TPU;
  localparam int T_SETUP   = (SETUP_US * TPU < 1) ? 1 : SETUP_US * TPU;
  localparam int T_BUF     = (BUF_US * TPU < 1) ? 1 : BUF_US * TPU;
  localparam int T_STRETCH = (STRETCH_US * TPU < 1) ? 1 : STRETCH_US * TPU;
  localparam int TW        = $clog2(T_STRETCH + T_BUF + T_LOW + 2) + 1;
  localparam logic [TW-1:0] LD_LOW     = TW'(T_LOW - 1);
  localparam logic [TW-1:0] LD_SETUP   = TW'(T_SETUP - 1);
  localparam logic [TW-1:0] LD_BUF     = TW'(T_BUF - 1);
  localparam logic [TW-1:0] LD_STRETCH = TW'(T_STRETCH - 1);
  localparam logic [TW-1:0] MIN_LOW    = TW'(T_LOW);
  localparam logic [TW-1:0] RUN_MAX    = {TW{1'b1}};

  localparam logic [1:0] OP_START = 2'b00;
  localparam logic [1:0] OP_STOP  = 2'b01;
  localparam logic [1:0] OP_WRITE = 2'b10;
  localparam logic [1:0] OP_READ  = 2'b11;

  typedef enum logic [2:0] {U_SDA_REL, U_SDA_LOW, U_SCL_HI, U_SCL_SMP, U_SCL_LO, U_BUF, U_END} uop_t;
  typedef enum logic [1:0] {S_IDLE, S_OP, S_WAIT, S_RISE} st_t;

  st_t           st;
  uop_t          uop;
  logic [1:0]    op_q;
  logic          last_q;
  logic [7:0]    sreg;
  logic [2:0]    bitcnt;
  logic [3:0]    step;
  logic [TW-1:0] tmr;
  logic          scl_oe_q, sda_oe_q, done_q, ack_q, err_q;
  logic [7:0]    rdata_q;
  logic          scl_m, scl_s, sda_m, sda_s;
  logic          loop_back;

  assign busy   = (st != S_IDLE);
  assign done   = done_q;
  assign rdata  = rdata_q;
  assign ack    = ack_q;
  assign err    = err_q;
  assign scl_oe = scl_oe_q;
  assign sda_oe = sda_oe_q;

  assign loop_back = op_q[1] && (step == 4'd2) && (bitcnt != 3'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {scl_m, scl_s, sda_m, sda_s} <= 4'b1111;
    else        {scl_m, scl_s, sda_m, sda_s} <= {scl_in, scl_m, sda_in, sda_m};

  always_comb begin
    uop = U_END;
    unique case (op_q)
      OP_START:
        case (step)
          4'd0: uop = U_SDA_REL;
          4'd1: uop = U_SCL_HI;
          4'd2: uop = U_SDA_LOW;
          4'd3: uop = U_SCL_LO;
          default: uop = U_END;
        endcase
      OP_STOP:
        case (step)
          4'd0: uop = U_SCL_LO;
          4'd1: uop = U_SDA_LOW;
          4'd2: uop = U_SCL_HI;
          4'd3: uop = U_SDA_REL;
          4'd4: uop = U_BUF;
          default: uop = U_END;
        endcase
      OP_WRITE:
        case (step)
          4'd0: uop = sreg[7] ? U_SDA_REL : U_SDA_LOW;
          4'd1: uop = U_SCL_HI;
          4'd2: uop = U_SCL_LO;
          4'd3: uop = U_SDA_REL;
          4'd4: uop = U_SCL_SMP;
          4'd5: uop = U_SCL_LO;
          default: uop = U_END;
        endcase
      default:
        if (step == 4'd0)      uop = U_SDA_REL;
        else if (step == 4'd1) uop = U_SCL_SMP;
        else if (step == 4'd2) uop = U_SCL_LO;
        else if (!last_q)
          case (step)
            4'd3: uop = U_SDA_LOW;
            4'd4: uop = U_SCL_HI;
            4'd5: uop = U_SCL_LO;
            4'd6: uop = U_SDA_REL;
            default: uop = U_END;
          endcase
        else
          case (step)
            4'd3: uop = U_SCL_HI;
            4'd4: uop = U_SCL_LO;
            4'd5: uop = U_SDA_LOW;
            4'd6: uop = U_SCL_HI;
            4'd7: uop = U_SDA_REL;
            4'd8: uop = U_BUF;
            default: uop = U_END;
          endcase
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_q     <= OP_START;
      last_q   <= 1'b0;
      sreg     <= '0;
      bitcnt   <= '0;
      step     <= '0;
      tmr      <= '0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
      done_q   <= 1'b0;
      ack_q    <= 1'b0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE:
          if (cmd_valid) begin
            op_q   <= cmd_op;
            last_q <= cmd_last;
            sreg   <= cmd_wdata;
            bitcnt <= 3'd7;
            step   <= '0;
            err_q  <= 1'b0;
            if (cmd_op == OP_WRITE) ack_q <= 1'b0;
            st     <= S_OP;
          end
        S_OP:
          unique case (uop)
            U_SDA_REL: begin sda_oe_q <= 1'b0; tmr <= LD_SETUP; st <= S_WAIT; end
            U_SDA_LOW: begin sda_oe_q <= 1'b1; tmr <= LD_SETUP; st <= S_WAIT; end
            U_SCL_LO:  begin scl_oe_q <= 1'b1; tmr <= LD_LOW;   st <= S_WAIT; end
            U_SCL_HI, U_SCL_SMP: begin scl_oe_q <= 1'b0; tmr <= LD_STRETCH; st <= S_RISE; end
            U_BUF:     begin tmr <= LD_BUF; st <= S_WAIT; end
            default: begin
              done_q <= 1'b1;
              if (op_q == OP_READ) rdata_q <= sreg;
              st <= S_IDLE;
            end
          endcase
        S_WAIT:
          if (tmr != '0) tmr <= tmr - 1'b1;
          else begin
            st <= S_OP;
            if (loop_back) begin
              bitcnt <= bitcnt - 3'd1;
              if (op_q == OP_WRITE) begin
                step <= 4'd0;
                sreg <= {sreg[6:0], 1'b0};
              end else step <= 4'd1;
            end else step <= step + 4'd1;
          end
        default:
          if (scl_s) begin
            if (uop == U_SCL_SMP) begin
              if (op_q == OP_READ) sreg <= {sreg[6:0], sda_s};
              else                 ack_q <= ~sda_s;
            end
            tmr <= LD_SETUP;
            st  <= S_WAIT;
          end else if (tmr == '0) begin
            scl_oe_q <= 1'b0;
            sda_oe_q <= 1'b0;
            err_q    <= 1'b1;
            done_q   <= 1'b1;
            st       <= S_IDLE;
          end else tmr <= tmr - 1'b1;
      endcase
    end
  end

  logic [TW-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        low_run <= '0;
    else if (scl_oe_q) low_run <= (low_run == RUN_MAX) ? low_run : low_run + 1'b1;
    else               low_run <= '0;

  p_scl_low_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe_q) |-> (low_run >= MIN_LOW));

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid) |=> busy);

  p_abort_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && err_q) |-> (!scl_oe_q && !sda_oe_q));

  p_abort_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && err_q) |-> $past(!scl_s));
endmodule

// File: tb/twowire_bit_engine_bench.sv
`timescale 1ns/1ps
module twowire_bit_engine_bench;
  localparam int CLK_HZ    = 4_000_000;
  localparam int T_LOW     = 8;
  localparam int T_BUF     = 240;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic       cmd_last = 1'b0;
  logic [7:0] cmd_wdata = 8'h00;
  logic       busy, done, ack, err, scl_oe, sda_oe;
  logic [7:0] rdata;

  logic hold_scl = 1'b0;
  logic rd_mode = 1'b0, wr_mode = 1'b0, ack_en = 1'b0;
  logic [7:0] rbyte = 8'h00;
  int fall_total = 0, fall_base = 0, idx;
  logic slave_pull;
  wire scl_bus = !(scl_oe || hold_scl);
  wire sda_bus = !(sda_oe || slave_pull);

  always_comb idx = fall_total - fall_base;
  always_comb slave_pull = (rd_mode && idx >= 0 && idx < 8 && !rbyte[3'(7 - idx)]) ||
                           (wr_mode && ack_en && idx == 8);

  twowire_bit_engine #(.CLK_HZ(CLK_HZ)) u_twowire_bit_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_last(cmd_last), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .rdata(rdata), .ack(ack), .err(err), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  always @(negedge scl_bus) fall_total <= fall_total + 1;

  logic [7:0] cap8 = 8'h00;
  logic ninth = 1'b0;
  always @(posedge scl_bus) begin
    if (idx >= 0 && idx < 8) cap8 <= {cap8[6:0], sda_bus};
    else if (idx == 8)       ninth <= sda_bus;
  end

  int starts = 0, stops = 0;
  always @(negedge sda_bus) if (scl_bus === 1'b1) starts <= starts + 1;
  always @(posedge sda_bus) if (scl_bus === 1'b1) stops <= stops + 1;

  int lowrun = 0, low_viol = 0, since_rel = 0, gap_at_done = 0, done_cnt = 0;
  always @(negedge clk) begin
    if (scl_bus === 1'b0) lowrun = lowrun + 1;
    else begin
      if (lowrun > 0 && lowrun < T_LOW) low_viol = low_viol + 1;
      lowrun = 0;
    end
    if (sda_oe === 1'b0) since_rel = since_rel + 1; else since_rel = 0;
    if (done === 1'b1) begin
      done_cnt = done_cnt + 1;
      gap_at_done = since_rel;
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_ninth(input logic is_read, input logic last, input logic ackd);
    return is_read ? last : !ackd;
  endfunction

  task automatic wait_done();
    int n = 0;
    while (done !== 1'b1 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 20000) chk(1'b0, "R11 done timeout", 32'(n), 32'd0);
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input logic last, input logic [7:0] data, input logic rm, input logic wm);
    @(negedge clk);
    fall_base = fall_total;
    rd_mode = rm;
    wr_mode = wm;
    cmd_op = op; cmd_last = last; cmd_wdata = data; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
  endtask

  task automatic do_write(input logic [7:0] d, input logic a);
    ack_en = a;
    issue(2'b10, 1'b0, d, 1'b0, 1'b1);
    chk(cap8 == d, "R5 write bits", 32'(cap8), 32'(d));
    chk(ninth == exp_ninth(1'b0, 1'b0, a), "R6 ninth-clock data", 32'(ninth), 32'(exp_ninth(1'b0, 1'b0, a)));
    chk(ack == a, "R6 ack", 32'(ack), 32'(a));
    chk(scl_oe == 1'b1 && sda_oe == 1'b0, "R7 lines after write", {30'd0, scl_oe, sda_oe}, 32'd2);
  endtask

  task automatic do_read(input logic [7:0] d, input logic last);
    int s0;
    s0 = stops;
    rbyte = d;
    issue(2'b11, last, 8'h00, 1'b1, 1'b0);
    chk(rdata == d, last ? "R9 rdata" : "R8 rdata", 32'(rdata), 32'(d));
    chk(ninth == exp_ninth(1'b1, last, 1'b0), last ? "R9 nack" : "R8 master ack",
        32'(ninth), 32'(exp_ninth(1'b1, last, 1'b0)));
    if (last) begin
      chk(stops == s0 + 1, "R9 stop after last", 32'(stops), 32'(s0 + 1));
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R9 released", {30'd0, scl_oe, sda_oe}, 32'd0);
      chk(gap_at_done >= T_BUF, "R10 bus-free after read", 32'(gap_at_done), 32'(T_BUF));
    end else
      chk(sda_oe == 1'b0, "R8 data released", 32'(sda_oe), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0, d0;
    logic [7:0] d;
    void'($urandom(32'h1d2c3b4a));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0 && busy == 0 && done == 0 && ack == 0 && err == 0,
        "R1 reset state", {26'd0, scl_oe, sda_oe, busy, done, ack, err}, 32'd0);

    s0 = starts;
    issue(2'b00, 1'b0, 8'h00, 1'b0, 1'b0);
    chk(starts == s0 + 1, "R4 start seen", 32'(starts), 32'(s0 + 1));
    chk(scl_oe && sda_oe, "R4 lines held low", {30'd0, scl_oe, sda_oe}, 32'd3);

    do_write(8'h00, 1'b1);
    do_write(8'hFF, 1'b1);
    for (int i = 0; i < 6; i++) do_write(8'($urandom), 1'($urandom));
    for (int i = 0; i < 4; i++) do_read(8'($urandom), 1'b0);
    do_read(8'hA5, 1'b1);

    s0 = starts;
    issue(2'b00, 1'b0, 8'h00, 1'b0, 1'b0);
    chk(starts == s0 + 1, "R4 repeated start", 32'(starts), 32'(s0 + 1));
    s0 = stops;
    issue(2'b01, 1'b0, 8'h00, 1'b0, 1'b0);
    chk(stops == s0 + 1, "R10 stop seen", 32'(stops), 32'(s0 + 1));
    chk(gap_at_done >= T_BUF, "R10 bus-free gap", 32'(gap_at_done), 32'(T_BUF));
    chk(!scl_oe && !sda_oe, "R10 released", {30'd0, scl_oe, sda_oe}, 32'd0);

    issue(2'b00, 1'b0, 8'h00, 1'b0, 1'b0);
    d = 8'($urandom);
    d0 = done_cnt;
    ack_en = 1'b1;
    @(negedge clk);
    fall_base = fall_total; wr_mode = 1'b1; rd_mode = 1'b0;
    cmd_op = 2'b10; cmd_wdata = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy == 1'b1, "R11 busy mid-write", 32'(busy), 32'd1);
    cmd_op = 2'b11; cmd_wdata = ~d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    repeat (400) @(negedge clk);
    chk(done_cnt == d0 + 1, "R11 single done", 32'(done_cnt), 32'(d0 + 1));
    chk(cap8 == d, "R11 byte unchanged", 32'(cap8), 32'(d));
    issue(2'b01, 1'b0, 8'h00, 1'b0, 1'b0);

    s0 = starts;
    hold_scl = 1'b1;
    fork
      issue(2'b00, 1'b0, 8'h00, 1'b0, 1'b0);
      begin repeat (3980) @(negedge clk); hold_scl = 1'b0; end
    join
    chk(err == 1'b0, "R3 stretch accepted", 32'(err), 32'd0);
    chk(starts == s0 + 1, "R3 start after stretch", 32'(starts), 32'(s0 + 1));
    issue(2'b01, 1'b0, 8'h00, 1'b0, 1'b0);

    hold_scl = 1'b1;
    issue(2'b00, 1'b0, 8'h00, 1'b0, 1'b0);
    chk(err == 1'b1, "R12 timeout flagged", 32'(err), 32'd1);
    chk(!scl_oe && !sda_oe, "R12 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);
    hold_scl = 1'b0;
    repeat (10) @(negedge clk);
    issue(2'b01, 1'b0, 8'h00, 1'b0, 1'b0);
    chk(err == 1'b0, "R12 err cleared", 32'(err), 32'd0);

    chk(low_viol == 0, "R2 clock low hold", 32'(low_viol), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule